// File: doc/BRIEF.md
# Register-Mapped Two-Wire Target with Alert Reply

This block is a two-wire serial (I2C/SMBus) target that sits in front of a small bank of byte registers. It watches oversampled copies of the clock and data lines and pulls the data line low to acknowledge or to send bits. It presents each register access to the surrounding logic as a one-cycle read or write strobe with an address and data. The master sets a register pointer with a write. It then either keeps writing data bytes, or issues a repeated START and reads bytes back. The pointer advances by one per byte and wraps at the top of the map.

The block also owns a shared, open-drain interrupt line. A one-cycle event strobe from the core logic makes it pull that line low. A master that sees the line low polls the SMBus alert response address. While its interrupt is pending, this target acknowledges that poll and answers with its own address byte. As it sends that byte it checks the data line on every clock rise. If it finds a 0 where it sent a 1, another responder with a lower address has won. The target then goes quiet and keeps its interrupt pending for the next poll. Only a complete, uncontested reply clears the interrupt.

Top module: `i2c_alert_target`

## Requirements
- R1: After reset the data pull-down and the interrupt pull-down are both released, and neither register strobe is active.
- R2: A first byte whose upper seven bits equal the device address 1100100 is acknowledged, whatever the direction bit (bit 0; 0 = write, 1 = read). Any other first byte, apart from an accepted alert poll, gets no acknowledge, and the target leaves the data line alone until the next START.
- R3: In a write, the first byte after the address loads the register pointer. Each later byte is acknowledged and stored through a write strobe at the pointer, and the pointer then moves up by one.
- R4: The pointer takes the low ADDR_W bits of the pointer byte. It wraps from the highest register (NUM_REGS-1) back to 0, for writes and for reads.
- R5: Registers below RO_REGS (by default only register 0, the status byte) are read-only. A data byte aimed at one of them is acknowledged, but no write strobe is issued and the register keeps its value.
- R6: After a repeated START with the read bit set, the target sends bytes MSB first from consecutive registers, beginning at the pointer. It goes on while the master acknowledges. After the master's not-acknowledge it releases the data line.
- R7: A pulse on the alert event input makes the interrupt pull-down active on the next clock. It then stays active until an alert reply completes.
- R8: The alert poll byte 0001100 with the read bit set (18h, 1) is acknowledged only while the interrupt pull-down is active. Otherwise it gets no acknowledge.
- R9: After acknowledging the poll, the target sends C9h (its address followed by a 1). The interrupt pull-down is released once the last bit of that byte has been sent, and later polls get no acknowledge until a new alert event.
- R10: If, while sending C9h, the target sends a 1 and samples a 0 on a clock rise, it releases the data line for the rest of the byte. The interrupt stays active, and the next poll is answered again.
- R11: The data pull-down changes only while the clock line is low.
- R12: A START (data falling while the clock is high) restarts address reception from any state, even in the middle of a byte. A STOP (data rising while the clock is high) returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| alert_evt_i | input | 1 | One-cycle strobe from the core that raises an interrupt |
| sda_pd_o | output | 1 | Data line pull-down enable (1 = drive low) |
| alert_pd_o | output | 1 | Interrupt line pull-down enable (1 = drive low) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe; read data is taken in the same cycle |
| reg_addr_o | output | ADDR_W | Current register pointer, the address of any strobe |
| reg_wdata_o | output | 8 | Write data that goes with reg_wr_o |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
The hardest case to reach from the ports is lost arbitration during the alert reply. It needs a second responder on the same wire, pulling the data line low bit by bit while the target is sending a 1. The bench models that responder as an extra open-drain driver that shares the wired-AND data line. During one poll it drives a lower address byte. The bench then checks three things: the master receives the other device's byte, the interrupt stays pending, and a second, uncontested poll returns C9h and clears it. A repeated START in the middle of a byte is another edge that ordinary traffic never produces, so the bench forces one as a directed case before a read.

// File: rtl/i2c_alert_pkg.sv
package i2c_alert_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } tgt_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/i2c_line_mon.sv
module i2c_line_mon
  import i2c_alert_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic                   scl_q, sda_q;
  logic                   scl_now, sda_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_now = scl_sh[SYNC_STAGES-1];
  assign sda_now = sda_sh[SYNC_STAGES-1];

  always_comb begin
    ev.scl      = scl_now;
    ev.sda      = sda_now;
    ev.scl_rise = scl_now & ~scl_q;
    ev.scl_fall = ~scl_now & scl_q;
    ev.start    = scl_now & scl_q & sda_q & ~sda_now;
    ev.stop     = scl_now & scl_q & ~sda_q & sda_now;
  end
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int ADDR_W  = 2,
  parameter int RO_REGS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_en,
  output logic [ADDR_W-1:0] ptr,
  output logic              ptr_ro
);
  logic [ADDR_W-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr;
    if (load_en)     ptr_n = load_val;
    else if (inc_en) ptr_n = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_n;
  end

  generate
    if (RO_REGS == 0) begin : g_all_rw
      assign ptr_ro = 1'b0;
    end else begin : g_ro_low
      assign ptr_ro = (int'(ptr) < RO_REGS);
    end
  endgenerate
endmodule

// File: rtl/i2c_alert_flag.sv
module i2c_alert_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic done,
  output logic pending
);
  logic pending_n;

  always_comb begin
    pending_n = pending;
    if (evt)       pending_n = 1'b1;
    else if (done) pending_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pending_n;
  end
endmodule

// File: rtl/i2c_alert_target.sv
module i2c_alert_target
  import i2c_alert_pkg::*;
#(
  parameter int         ADDR_W      = 2,
  parameter int         RO_REGS     = 1,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h64,
  parameter logic [6:0] POLL_ADDR   = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              alert_evt_i,
  output logic              sda_pd_o,
  output logic              alert_pd_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i
);
  localparam int         NUM_REGS  = 1 << ADDR_W;
  localparam logic [7:0] POLL_BYTE = {POLL_ADDR, 1'b1};
  localparam logic [7:0] REPLY     = {DEV_ADDR, 1'b1};
  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic       rst_i_n;
  bus_ev_t    ev;
  logic       scl_seen;

  tgt_state_e st, st_n;
  logic [3:0] cnt, cnt_n;
  logic [7:0] rx, rx_n;
  logic [7:0] tx, tx_n;
  logic       pd, pd_n;
  logic       rdir, rdir_n;
  logic       ara, ara_n;
  logic       mack, mack_n;

  logic       ptr_ld, ptr_inc, ptr_ro;
  logic [ADDR_W-1:0] ptr;
  logic       wr_stb, rd_stb, reply_done, alert_on;

  i2c_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_i_n), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
  );

  i2c_reg_ptr #(.ADDR_W(ADDR_W), .RO_REGS(RO_REGS)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .load_en(ptr_ld), .load_val(rx[ADDR_W-1:0]),
    .inc_en(ptr_inc), .ptr(ptr), .ptr_ro(ptr_ro)
  );

  i2c_alert_flag u_alert (
    .clk(clk), .rst_n(rst_i_n), .evt(alert_evt_i), .done(reply_done),
    .pending(alert_on)
  );

  assign scl_seen = ev.scl;

  always_comb begin
    st_n       = st;
    cnt_n      = cnt;
    rx_n       = rx;
    tx_n       = tx;
    pd_n       = pd;
    rdir_n     = rdir;
    ara_n      = ara;
    mack_n     = mack;
    ptr_ld     = 1'b0;
    ptr_inc    = 1'b0;
    wr_stb     = 1'b0;
    rd_stb     = 1'b0;
    reply_done = 1'b0;

    if (ev.stop) begin
      st_n = ST_IDLE;
      pd_n = 1'b0;
    end else if (ev.start) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      pd_n  = 1'b0;
      ara_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (ev.scl_rise && cnt != BYTE_BITS) begin
            rx_n  = {rx[6:0], ev.sda};
            cnt_n = cnt + 4'd1;
          end else if (ev.scl_fall && cnt == BYTE_BITS) begin
            cnt_n = '0;
            if (st == ST_ADDR) begin
              if (rx[7:1] == DEV_ADDR) begin
                pd_n   = 1'b1;
                rdir_n = rx[0];
                ara_n  = 1'b0;
                st_n   = ST_ADDR_ACK;
              end else if (rx == POLL_BYTE && alert_on) begin
                pd_n   = 1'b1;
                rdir_n = 1'b1;
                ara_n  = 1'b1;
                st_n   = ST_ADDR_ACK;
              end else begin
                st_n = ST_HOLD;
              end
            end else if (st == ST_PTR) begin
              pd_n   = 1'b1;
              ptr_ld = 1'b1;
              st_n   = ST_PTR_ACK;
            end else begin
              pd_n   = 1'b1;
              wr_stb = ~ptr_ro;
              st_n   = ST_WDAT_ACK;
            end
          end
        end

        ST_ADDR_ACK: begin
          if (ev.scl_fall) begin
            cnt_n = '0;
            if (ara) begin
              tx_n = REPLY;
              pd_n = ~REPLY[7];
              st_n = ST_TX;
            end else if (rdir) begin
              tx_n    = reg_rdata_i;
              pd_n    = ~reg_rdata_i[7];
              rd_stb  = 1'b1;
              ptr_inc = 1'b1;
              st_n    = ST_TX;
            end else begin
              pd_n = 1'b0;
              st_n = ST_PTR;
            end
          end
        end

        ST_PTR_ACK, ST_WDAT_ACK: begin
          if (ev.scl_fall) begin
            pd_n    = 1'b0;
            cnt_n   = '0;
            ptr_inc = (st == ST_WDAT_ACK);
            st_n    = ST_WDAT;
          end
        end

        ST_TX: begin
          if (ev.scl_rise && ara && !pd && !ev.sda) begin
            pd_n = 1'b0;
            st_n = ST_HOLD;
          end else if (ev.scl_fall) begin
            if (cnt == BYTE_BITS - 4'd1) begin
              pd_n       = 1'b0;
              st_n       = ST_TX_ACK;
              reply_done = ara;
            end else begin
              tx_n  = {tx[6:0], 1'b0};
              pd_n  = ~tx[6];
              cnt_n = cnt + 4'd1;
            end
          end
        end

        ST_TX_ACK: begin
          if (ev.scl_rise) begin
            mack_n = ~ev.sda;
          end else if (ev.scl_fall) begin
            cnt_n = '0;
            if (mack && !ara) begin
              tx_n    = reg_rdata_i;
              pd_n    = ~reg_rdata_i[7];
              rd_stb  = 1'b1;
              ptr_inc = 1'b1;
              st_n    = ST_TX;
            end else begin
              pd_n = 1'b0;
              st_n = ST_HOLD;
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      rx   <= '0;
      tx   <= '0;
      pd   <= 1'b0;
      rdir <= 1'b0;
      ara  <= 1'b0;
      mack <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      rx   <= rx_n;
      tx   <= tx_n;
      pd   <= pd_n;
      rdir <= rdir_n;
      ara  <= ara_n;
      mack <= mack_n;
    end
  end

  assign sda_pd_o    = pd;
  assign alert_pd_o  = alert_on;
  assign reg_wr_o    = wr_stb;
  assign reg_rd_o    = rd_stb;
  assign reg_addr_o  = ptr;
  assign reg_wdata_o = rx;

  if (NUM_REGS < 2) begin : g_bad_size
    initial $error("register map needs at least two entries");
  end
endmodule

// File: rtl/i2c_alert_target_chk.sv
module i2c_alert_target_chk #(
  parameter int ADDR_W  = 2,
  parameter int RO_REGS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_seen,
  input logic              alert_evt_i,
  input logic              sda_pd_o,
  input logic              alert_pd_o,
  input logic              reg_wr_o,
  input logic              reg_rd_o,
  input logic [ADDR_W-1:0] reg_addr_o
);
  p_pd_change_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> !$past(scl_seen));

  p_no_ro_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (int'(reg_addr_o) >= RO_REGS));

  p_alert_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alert_evt_i |=> alert_pd_o);

  p_alert_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pd_o) |-> !$past(alert_evt_i));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));
endmodule

bind i2c_alert_target i2c_alert_target_chk #(.ADDR_W(ADDR_W), .RO_REGS(RO_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_seen(scl_seen), .alert_evt_i(alert_evt_i),
  .sda_pd_o(sda_pd_o), .alert_pd_o(alert_pd_o), .reg_wr_o(reg_wr_o),
  .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_alert_target_test.sv
`timescale 1ns/1ps
module i2c_alert_target_test;
  localparam int         NREG = 4;
  localparam int         Q    = 10;
  localparam logic [6:0] DEV  = 7'h64;
  localparam logic [6:0] POLL = 7'h0C;

  logic       clk, rst_n, scl, m_sda, oth_pd, alert_evt;
  logic       sda_pd_o, alert_pd_o, reg_wr_o, reg_rd_o;
  logic [1:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  wire        sda_line = m_sda & ~sda_pd_o & ~oth_pd;

  logic [7:0] rf [NREG];
  logic [7:0] expv [NREG];
  int total, bad, mptr, viol, hi_cnt;
  bit done, exp_alert;

  i2c_alert_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .alert_evt_i(alert_evt), .sda_pd_o(sda_pd_o), .alert_pd_o(alert_pd_o),
    .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    case (i)
      0: return 8'h81;
      1: return 8'h3C;
      2: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int next_ptr(int p);
    return (p + 1) % NREG;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= init_val(i);
    end else if (reg_wr_o) begin
      rf[reg_addr_o] <= reg_wdata_o;
    end
  end
  assign reg_rdata_i = rf[reg_addr_o];

  // R11 monitor: the data pull-down must not move while the clock has been high a while
  logic pd_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_cnt  <= 0;
      pd_prev <= 1'b0;
    end else begin
      hi_cnt  <= scl ? hi_cnt + 1 : 0;
      pd_prev <= sda_pd_o;
      if (scl && hi_cnt > 5 && sda_pd_o != pd_prev) viol <= viol + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(Q);
    scl   = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    scl   = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(Q);
    scl   = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic bit_cyc(input logic b, output logic s);
    m_sda = b; wq(Q);
    scl = 1'b1; wq(Q);
    s = sda_line; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
    bit_cyc(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit mack, input bit arb, input logic [7:0] ob,
                           output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      oth_pd = arb & ~ob[i];
      bit_cyc(1'b1, s);
      b[i] = s;
    end
    oth_pd = 1'b0;
    bit_cyc(~mack, s);
  endtask

  task automatic do_write(input int p0, input int n);
    logic ack;
    logic [7:0] d;
    int p;
    i2c_start;
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2 write address ack", ack, 1);
    send_byte(8'(p0), ack);      chk(ack, "R3 pointer ack", ack, 1);
    p = p0 % NREG;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk(ack, "R3 data ack", ack, 1);
      if (p >= 1) expv[p] = d;
      p = next_ptr(p);
    end
    i2c_stop;
    mptr = p;
  endtask

  task automatic do_read(input bit set_ptr, input int p0, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    int p;
    if (set_ptr) begin
      i2c_start;
      send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
      send_byte(8'(p0), ack);      chk(ack, "R3 pointer ack", ack, 1);
      p = p0 % NREG;
    end else begin
      p = mptr;
    end
    i2c_start;
    send_byte({DEV, 1'b1}, ack); chk(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, 1'b0, 8'h00, b);
      chk(b == expv[p], tag, b, expv[p]);
      p = next_ptr(p);
    end
    chk(sda_pd_o == 1'b0, "R6 release after master nack", sda_pd_o, 0);
    i2c_stop;
    mptr = p;
  endtask

  task automatic do_bad_addr;
    logic ack;
    logic [6:0] a;
    logic [7:0] b;
    a = 7'($urandom);
    while (a == DEV || a == POLL) a = 7'($urandom);
    i2c_start;
    send_byte({a, 1'($urandom)}, ack);
    chk(!ack, "R2 foreign address nack", ack, 0);
    b = 8'($urandom);
    send_byte(b, ack);
    chk(!ack, "R2 silent after foreign address", ack, 0);
    i2c_stop;
  endtask

  task automatic pulse_alert;
    alert_evt = 1'b1; wq(1);
    alert_evt = 1'b0; wq(2);
    exp_alert = 1'b1;
    chk(alert_pd_o == 1'b1, "R7 alert raised", alert_pd_o, 1);
  endtask

  task automatic do_poll(input bit arb, input logic [7:0] ob);
    logic ack;
    logic [7:0] b;
    i2c_start;
    send_byte({POLL, 1'b1}, ack);
    chk(ack == exp_alert, "R8 poll ack only while alert pending", ack, exp_alert);
    if (ack) begin
      recv_byte(1'b0, arb, ob, b);
      if (arb) begin
        chk(b == ob, "R10 lower address wins", b, ob);
      end else begin
        chk(b == 8'hC9, "R9 reply byte", b, 8'hC9);
        exp_alert = 1'b0;
      end
    end
    i2c_stop;
    wq(2);
    chk(alert_pd_o == exp_alert, arb ? "R10 alert kept" : "R9 alert state after poll",
        alert_pd_o, exp_alert);
  endtask

  initial begin
    logic ack;
    logic s;
    scl = 1'b1; m_sda = 1'b1; oth_pd = 1'b0; alert_evt = 1'b0;
    total = 0; bad = 0; viol = 0; mptr = 0; done = 1'b0; exp_alert = 1'b0;
    for (int i = 0; i < NREG; i++) expv[i] = init_val(i);
    void'($urandom(32'h5EED_0A1C));
    rst_n = 1'b0;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    // R1 reset state
    chk(sda_pd_o == 0, "R1 data released", sda_pd_o, 0);
    chk(alert_pd_o == 0, "R1 alert released", alert_pd_o, 0);
    chk(!reg_wr_o && !reg_rd_o, "R1 strobes idle", {reg_wr_o, reg_rd_o}, 0);

    // R3 and R6 basic write then read-back with repeated start
    do_write(2, 2);
    do_read(1'b1, 2, 2, "R6 read back");
    // R5 write to the status register is discarded
    do_write(0, 1);
    do_read(1'b1, 0, 1, "R5 status unchanged");
    // R4 wrap on write (3 -> 0 -> 1) and on read
    do_write(3, 3);
    do_read(1'b1, 3, 3, "R4 wrap read");
    // R12 repeated START in the middle of a byte
    i2c_start;
    send_byte({DEV, 1'b0}, ack);
    bit_cyc(1'b0, s); bit_cyc(1'b1, s); bit_cyc(1'b1, s);
    do_read(1'b1, 1, 1, "R12 restart mid byte");
    // R8 poll without pending alert
    do_poll(1'b0, 8'h00);
    // R7, R10 lost arbitration, then R9 clean reply and later refusal
    pulse_alert;
    do_poll(1'b1, 8'h21);
    do_poll(1'b0, 8'h00);
    do_poll(1'b0, 8'h00);
    do_bad_addr;

    // random mix
    for (int it = 0; it < 24; it++) begin
      case ($urandom_range(0, 4))
        0: do_write($urandom_range(0, NREG - 1), $urandom_range(1, 4));
        1: do_read(1'b1, $urandom_range(0, NREG - 1), $urandom_range(1, 5), "R6 random read");
        2: do_read(1'b0, 0, $urandom_range(1, 3), "R6 read at current pointer");
        3: do_bad_addr;
        default: begin
          if ($urandom_range(0, 1) == 1) pulse_alert;
          do_poll(1'b0, 8'h00);
        end
      endcase
    end
    chk(viol == 0, "R11 data moved only with clock low", viol, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule